// File: doc/BRIEF.md
# Keypad Combination Lock Controller

This block is a Moore-style controller that opens a lock only when a fixed four-digit decimal code is keyed in order, one digit per key press. The keypad supplies a 4-bit digit value and a raw digit-valid strobe that is asynchronous to the clock. Inside the block the strobe passes through a two-flop synchroniser. A rising-edge detector then turns each press into a single one-cycle digit event.

Entry that goes wrong is not retried with overlap. Any wrong digit drops the machine into an absorbing error state, and it stays there until the clear input is asserted. Clear is also how an opened lock is relocked. The current state and the digit event are brought out as debug outputs.

Top module: `combo_lock`

## Requirements
- R1: The code is a parameter of four decimal digits that defaults to 1, 3, 9, 7. Four events carrying exactly those digits in order, starting from idle, reach the open state.
- R2: `state_o` shows the state register with this encoding: 0 idle, 1 one digit correct, 2 two digits correct, 3 three digits correct, 4 open, 5 error.
- R3: `unlock_o` is registered and high exactly when the state is open (4), with no dependence on the current inputs.
- R4: In idle, an event whose digit differs from the first code digit moves the machine to error (5).
- R5: In states 1 to 3, only the next expected code digit advances the machine. Any other digit moves it to error, and the code must then be entered again from the first digit after a clear.
- R6: In error, further digit events, including correct code digits, leave the state at error.
- R7: In open, further digit events are ignored, so the state stays at 4 and `unlock_o` stays high.
- R8: With `clear_i` high at a clock edge, the next state is idle from any state. Clear takes priority over a digit event in the same cycle.
- R9: `press_raw_i` goes through two flip-flops in series. `evt_o` is high for exactly one cycle per press, however long the press is held. A state change caused by a press appears after the third rising clock edge following the rise of `press_raw_i`.
- R10: `digit_i` is sampled only in the cycle in which `evt_o` is high. In cycles without an event the state does not change, whatever `digit_i` holds.
- R11: While `rst` is high, the block enters idle with `unlock_o` low and `evt_o` low. Unused state encodings 6 and 7 return to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| digit_i | input | 4 | Digit value from the keypad |
| press_raw_i | input | 1 | Raw asynchronous digit-valid strobe |
| clear_i | input | 1 | Clear / relock, synchronous, active high |
| unlock_o | output | 1 | Registered unlock |
| state_o | output | 3 | Debug: current state encoding |
| evt_o | output | 1 | Debug: one-cycle digit event after sync and edge detection |

## Verification
A detected digit event and a clear request can fall on the same clock edge. The bench forces this overlap by raising the strobe and then asserting clear exactly in the cycle where the event is high. This is done from the one-correct-digit state with the correct second digit on the bus. The overlap passes only if the state goes to idle rather than advancing. A per-cycle behavioural reference model confirms that no later cycle carries a leftover effect of the press.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ONE   = 3'd1,
        ST_TWO   = 3'd2,
        ST_THREE = 3'd3,
        ST_OPEN  = 3'd4,
        ST_ERR   = 3'd5
    } lock_state_t;

    typedef struct packed {
        lock_state_t state;
        logic        unlock;
    } fsm_regs_t;

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_regs_t;

endpackage

// File: rtl/press_sync.sv
module press_sync
    import combo_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic evt_o
);

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.meta = raw_i;
        r_d.sync = r_q.meta;
        r_d.prev = r_q.sync;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign evt_o = r_q.sync & ~r_q.prev;

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt_o |=> !evt_o);                                          // R9

    AST_EVT_FROM_RAW: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> $past(raw_i, 2));                                 // R9

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import combo_lock_pkg::*;
#(
    parameter logic [15:0] CODE = 16'h1397
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        evt_i,
    input  logic [3:0]  digit_i,
    input  logic        clear_i,
    output logic        unlock_o,
    output logic [2:0]  state_o
);

    localparam int NDIG = 4;
    localparam int DW   = $bits(CODE) / NDIG;

    function automatic logic [DW-1:0] code_digit(input int idx);
        return CODE[(NDIG-1-idx)*DW +: DW];
    endfunction

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d.state = ST_IDLE;
        end else begin
            case (r_q.state)
                ST_IDLE:  if (evt_i) r_d.state = (digit_i == code_digit(0)) ? ST_ONE   : ST_ERR;
                ST_ONE:   if (evt_i) r_d.state = (digit_i == code_digit(1)) ? ST_TWO   : ST_ERR;
                ST_TWO:   if (evt_i) r_d.state = (digit_i == code_digit(2)) ? ST_THREE : ST_ERR;
                ST_THREE: if (evt_i) r_d.state = (digit_i == code_digit(3)) ? ST_OPEN  : ST_ERR;
                ST_OPEN:  r_d.state = ST_OPEN;
                ST_ERR:   r_d.state = ST_ERR;
                default:  r_d.state = ST_IDLE;
            endcase
        end
        r_d.unlock = (r_d.state == ST_OPEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state  <= ST_IDLE;
            r_q.unlock <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign unlock_o = r_q.unlock;
    assign state_o  = r_q.state;

    AST_UNLOCK_MOORE: assert property (@(posedge clk) disable iff (rst)
        unlock_o == (state_o == ST_OPEN));                          // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_ERR && !clear_i) |=> state_o == ST_ERR);     // R6

    AST_OPEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_OPEN && !clear_i) |=> unlock_o);             // R7

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> state_o == ST_IDLE);                            // R8

    AST_NO_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!evt_i && !clear_i && state_o <= ST_ERR) |=> $stable(state_o)); // R10

endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import combo_lock_pkg::*;
#(
    parameter logic [15:0] CODE = 16'h1397
)(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] digit_i,
    input  logic       press_raw_i,
    input  logic       clear_i,
    output logic       unlock_o,
    output logic [2:0] state_o,
    output logic       evt_o
);

    logic evt;

    press_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (press_raw_i),
        .evt_o (evt)
    );

    lock_fsm #(.CODE(CODE)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .digit_i  (digit_i),
        .clear_i  (clear_i),
        .unlock_o (unlock_o),
        .state_o  (state_o)
    );

    assign evt_o = evt;

endmodule

// File: tb/combo_lock_tb.sv
`timescale 1ns/1ps
module combo_lock_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] digit = 4'd0;
    logic       press = 1'b0;
    logic       clear = 1'b0;
    logic       unlock;
    logic [2:0] state;
    logic       evt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int evt_count = 0;
    bit done = 0;

    int code [4] = '{1, 3, 9, 7};
    int m_state = 0;
    int hist [$] = '{0, 0, 0};

    always #2 clk = ~clk;

    combo_lock u_dut (
        .clk(clk), .rst(rst), .digit_i(digit), .press_raw_i(press),
        .clear_i(clear), .unlock_o(unlock), .state_o(state), .evt_o(evt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_state = 0;
            hist = '{0, 0, 0};
        end else begin
            bit e;
            e = (hist[1] == 1) && (hist[2] == 0);
            if (clear) m_state = 0;
            else if (e) begin
                if (m_state <= 3)
                    m_state = (int'(digit) == code[m_state]) ? m_state + 1 : 5;
            end
            hist.push_front(int'(press));
            void'(hist.pop_back());
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            int exp_evt;
            exp_evt = (hist[1] == 1 && hist[2] == 0) ? 1 : 0;
            check(int'(state) == m_state, "R2 state", int'(state), m_state);
            check(int'(unlock) == (m_state == 4 ? 1 : 0), "R3 unlock", int'(unlock), m_state == 4);
            check(int'(evt) == exp_evt, "R9 evt", int'(evt), exp_evt);
            if (evt) evt_count++;
        end
    end

    // press with digit held for the event, then scrambled while still held
    task automatic key(input int d, input int hold);
        @(negedge clk);
        digit = 4'(d);
        press = 1'b1;
        repeat (3) @(negedge clk);
        digit = 4'(d ^ 4'hF);            // R10: not sampled
        repeat (hold - 3) @(negedge clk);
        press = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(state == 3'd0 && !unlock && !evt, "R11 reset", int'(state), 0);
        rst = 1'b0;

        // R9: timing of the first press and single event on long hold
        @(negedge clk);
        digit = 4'd1; press = 1'b1; evt_count = 0;
        @(negedge clk);
        @(negedge clk);
        check(state == 3'd0, "R9 not yet", int'(state), 0);
        @(negedge clk);
        check(state == 3'd1, "R9 third edge", int'(state), 1);
        digit = 4'd8;
        repeat (10) @(negedge clk);
        check(state == 3'd1, "R10 digit ignored", int'(state), 1);
        press = 1'b0;
        repeat (3) @(negedge clk);
        check(evt_count == 1, "R9 one event", evt_count, 1);

        // R1: remaining digits
        key(3, 4); check(state == 3'd2, "R1 two", int'(state), 2);
        key(9, 5); check(state == 3'd3, "R1 three", int'(state), 3);
        key(7, 3); check(state == 3'd4 && unlock, "R1 open", int'(state), 4);

        // R7: digits ignored in open
        key(2, 3); key(1, 4);
        check(state == 3'd4 && unlock, "R7 open held", int'(state), 4);
        do_clear(); @(negedge clk);
        check(state == 3'd0 && !unlock, "R8 relock", int'(state), 0);

        // R4 and R6
        key(5, 3); check(state == 3'd5, "R4 wrong first", int'(state), 5);
        key(1, 3); key(3, 3);
        check(state == 3'd5, "R6 sticky", int'(state), 5);
        do_clear(); @(negedge clk);
        check(state == 3'd0, "R8 from error", int'(state), 0);

        // R5: wrong third digit, no restart without clear
        key(1, 3); key(3, 3); key(4, 3);
        check(state == 3'd5, "R5 wrong third", int'(state), 5);
        key(9, 3); key(7, 3);
        check(state == 3'd5 && !unlock, "R5 no resume", int'(state), 5);
        do_clear();
        key(1, 3); key(3, 3); key(9, 3); key(0, 3);
        check(state == 3'd5, "R5 wrong fourth", int'(state), 5);
        do_clear();

        // R8: clear coincides with a correct digit event
        key(1, 3);
        @(negedge clk);
        digit = 4'd3; press = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(evt == 1'b1, "R8 overlap evt", int'(evt), 1);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check(state == 3'd0, "R8 clear wins", int'(state), 0);
        press = 1'b0;
        repeat (4) @(negedge clk);
        check(state == 3'd0, "R8 no late effect", int'(state), 0);

        // R1 again after everything
        key(1, 3); key(3, 3); key(9, 3); key(7, 3);
        check(unlock == 1'b1, "R1 reopen", int'(unlock), 1);

        // R11: reset from open
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(state == 3'd0 && !unlock, "R11 reset open", int'(state), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule